// File: doc/BRIEF.md
# Byte-Indexed Table Lookup Unit

This unit builds a 32-bit result word one byte at a time from a small table of bytes. The caller loads up to four 64-bit table registers through a write port. The unit reads those registers as one byte array of up to 32 entries. A request then supplies three things: an index word that carries four byte indices, a default word, and a table length. Each lane reads its own index. If that index falls inside the active part of the table, the lane returns the addressed table byte. If it does not, the lane returns its own byte of the default word.

The four lanes work side by side and do not depend on one another. Each result byte lands in the lane its index came from. The result is registered, and a valid strobe marks it one cycle after the request strobe. The table length says how many registers are active, counted from register 0. A caller can therefore keep a short table without clearing the upper registers.

Top module: `byte_lut_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all table registers, `res_valid` and `res_word` are cleared to zero, so a lookup right after reset returns zero bytes for in-range indices.
- R2: Lane k (k = 0..3) takes its index from `idx_word[8k+7:8k]` and is handled without regard to the other lanes.
- R3: `tbl_len` holds the number of active table registers minus one (0 to 3). An index is in range only when it is strictly below 8 × (`tbl_len` + 1), that is below 8, 16, 24 or 32.
- R4: For an in-range index, bits [7:3] pick the table register and bits [2:0] pick the byte inside it. Byte 0 is bits [7:0] of the register.
- R5: For an out-of-range index, the lane's result byte is the byte in the same lane of `dflt_word`.
- R6: The byte chosen for lane k is placed in `res_word[8k+7:8k]`, the same lane its index came from.
- R7: When `wr_en` is high at a clock edge, table register `wr_sel` takes `wr_data` at that edge. A request made in that same cycle still sees the old contents.
- R8: `res_valid` is high exactly in the cycle after each cycle in which `req` is high. When `req` is low, `res_word` keeps its previous value.
- R9: Any index of 32 or more, up to 255, is out of range whatever the table length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Table register write strobe |
| wr_sel | input | 2 | Table register selected for the write |
| wr_data | input | 64 | Data written to the table register |
| req | input | 1 | Lookup request strobe |
| idx_word | input | 32 | Four byte indices, one per lane |
| dflt_word | input | 32 | Per-lane fallback bytes for out-of-range indices |
| tbl_len | input | 2 | Active table registers minus one |
| res_valid | output | 1 | Result valid, one cycle after `req` |
| res_word | output | 32 | Registered lookup result |

## Verification
The assertions assume that `req`, `wr_en` and the data inputs are driven to known values in every cycle once reset is released. They also assume the default-byte check can sample `dflt_word` and the length in the request cycle itself. The stimulus changes every input half a clock away from the sampling edge and never leaves a strobe undriven. The stimulus covers every table length against indices placed on both sides of each limit. It also covers indices of 32 and above, lane orders that are reversed and repeated, and a write to a register in the same cycle as a read of that register. A long stretch of mixed random writes and lookups then runs against the behavioural model.

// File: rtl/byte_lut_pkg.sv
package byte_lut_pkg;
    parameter int unsigned LUT_NREG   = 4;
    parameter int unsigned LUT_REG_W  = 64;
    parameter int unsigned LUT_LANES  = 4;
    parameter int unsigned LUT_BYTE_W = 8;
endpackage

// File: rtl/byte_lut_bank.sv
module byte_lut_bank #(
    parameter int unsigned NREG  = byte_lut_pkg::LUT_NREG,
    parameter int unsigned REG_W = byte_lut_pkg::LUT_REG_W,
    localparam int unsigned SEL_W = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [REG_W-1:0]        wr_data,
    output logic [NREG*REG_W-1:0]   table_flat
);
    logic [REG_W-1:0] tbl_d [NREG];
    logic [REG_W-1:0] tbl_q [NREG];

    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            tbl_d[r] = tbl_q[r];
        end
        if (wr_en) begin
            tbl_d[wr_sel] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (rst) tbl_q[r] <= '0;
            else     tbl_q[r] <= tbl_d[r];
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign table_flat[g*REG_W +: REG_W] = tbl_q[g];

        // R7: a write lands in the selected register at the next edge
        a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == SEL_W'(g)) |=> table_flat[g*REG_W +: REG_W] == $past(wr_data));
        // R7: unselected registers keep their contents
        a_r7_others_hold: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_sel == SEL_W'(g)) |=> $stable(table_flat[g*REG_W +: REG_W]));
    end
endmodule

// File: rtl/byte_lut_lane.sv
module byte_lut_lane #(
    parameter int unsigned NREG   = byte_lut_pkg::LUT_NREG,
    parameter int unsigned REG_W  = byte_lut_pkg::LUT_REG_W,
    parameter int unsigned BYTE_W = byte_lut_pkg::LUT_BYTE_W,
    localparam int unsigned SEL_W = $clog2(NREG),
    localparam int unsigned BSEL_W = $clog2(REG_W / BYTE_W),
    localparam int unsigned POS_W = SEL_W + BSEL_W
) (
    input  logic [NREG*REG_W-1:0] table_flat,
    input  logic [BYTE_W-1:0]     lane_idx,
    input  logic [BYTE_W-1:0]     lane_dflt,
    input  logic [BYTE_W-1:0]     limit,
    output logic [BYTE_W-1:0]     lane_out
);
    logic              in_range;
    logic [POS_W-1:0]  pos;
    logic [BYTE_W-1:0] picked;

    always_comb begin
        in_range = lane_idx < limit;
        pos      = lane_idx[POS_W-1:0];
        picked   = table_flat[pos*BYTE_W +: BYTE_W];
        lane_out = in_range ? picked : lane_dflt;
    end
endmodule

// File: rtl/byte_lut_unit.sv
module byte_lut_unit #(
    parameter int unsigned NREG   = byte_lut_pkg::LUT_NREG,
    parameter int unsigned REG_W  = byte_lut_pkg::LUT_REG_W,
    parameter int unsigned LANES  = byte_lut_pkg::LUT_LANES,
    parameter int unsigned BYTE_W = byte_lut_pkg::LUT_BYTE_W,
    localparam int unsigned SEL_W = $clog2(NREG),
    localparam int unsigned WORD_W = LANES * BYTE_W,
    localparam int unsigned BPR   = REG_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              req,
    input  logic [WORD_W-1:0] idx_word,
    input  logic [WORD_W-1:0] dflt_word,
    input  logic [SEL_W-1:0]  tbl_len,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_word
);
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
    } res_state_t;

    res_state_t st_d, st_q;
    logic [NREG*REG_W-1:0] table_flat;
    logic [BYTE_W-1:0]     limit;
    logic [WORD_W-1:0]     lookup;

    byte_lut_bank #(.NREG(NREG), .REG_W(REG_W)) i_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .table_flat (table_flat)
    );

    always_comb begin
        limit = (BYTE_W'(tbl_len) + BYTE_W'(1)) * BYTE_W'(BPR);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        byte_lut_lane #(.NREG(NREG), .REG_W(REG_W), .BYTE_W(BYTE_W)) i_lane (
            .table_flat (table_flat),
            .lane_idx   (idx_word[k*BYTE_W +: BYTE_W]),
            .lane_dflt  (dflt_word[k*BYTE_W +: BYTE_W]),
            .limit      (limit),
            .lane_out   (lookup[k*BYTE_W +: BYTE_W])
        );

        // R5: out-of-range lanes return the same-lane default byte
        a_r5_default_byte: assert property (@(posedge clk) disable iff (rst)
            (req && idx_word[k*BYTE_W +: BYTE_W] >= limit)
            |=> res_word[k*BYTE_W +: BYTE_W] == $past(dflt_word[k*BYTE_W +: BYTE_W]));
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = req;
        if (req) begin
            st_d.word = lookup;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_valid = st_q.valid;
    assign res_word  = st_q.word;

    // R8: valid follows the request by exactly one cycle
    a_r8_valid_after_req: assert property (@(posedge clk) disable iff (rst)
        req |=> res_valid);
    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !req |=> !res_valid);
    // R8: result holds while no request is made
    a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
        !req |=> $stable(res_word));
endmodule

// File: tb/test_byte_lut_unit.sv
module test_byte_lut_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic        req = 1'b0;
    logic [31:0] idx_word = '0;
    logic [31:0] dflt_word = '0;
    logic [1:0]  tbl_len = '0;
    logic        res_valid;
    logic [31:0] res_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit armed = 0;
    string tag = "R1";

    logic [63:0] mt [4];
    logic        exp_v;
    logic [31:0] exp_w;

    always #10 clk = ~clk;

    byte_lut_unit i_byte_lut_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req(req), .idx_word(idx_word), .dflt_word(dflt_word), .tbl_len(tbl_len),
        .res_valid(res_valid), .res_word(res_word)
    );

    function automatic logic [31:0] ref_lookup(logic [31:0] iw, logic [31:0] dw, logic [1:0] ln);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) begin
            int i = int'(iw[k*8 +: 8]);
            int lim = 8 * (int'(ln) + 1);
            if (i < lim) r[k*8 +: 8] = mt[i / 8][(i % 8) * 8 +: 8];
            else         r[k*8 +: 8] = dw[k*8 +: 8];
        end
        return r;
    endfunction

    // behavioural model: lookup uses table contents before this edge's write
    always @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < 4; r++) mt[r] = '0;
            exp_v = 1'b0;
            exp_w = '0;
            armed = 1'b1;
        end else begin
            exp_v = req;
            if (req) exp_w = ref_lookup(idx_word, dflt_word, tbl_len);
            if (wr_en) mt[wr_sel] = wr_data;
        end
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (res_valid !== exp_v) begin
                errors++;
                $display("FAIL %s res_valid actual %b expected %b", tag, res_valid, exp_v);
            end
            checks++;
            if (res_word !== exp_w) begin
                errors++;
                $display("FAIL %s res_word actual %h expected %h", tag, res_word, exp_w);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0;
        req = 1'b0;
    endtask

    task automatic do_write(logic [1:0] s, logic [63:0] d);
        @(negedge clk);
        req = 1'b0;
        wr_en = 1'b1; wr_sel = s; wr_data = d;
    endtask

    task automatic do_req(logic [31:0] iw, logic [31:0] dw, logic [1:0] ln);
        @(negedge clk);
        wr_en = 1'b0;
        req = 1'b1; idx_word = iw; dflt_word = dw; tbl_len = ln;
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        do_req(32'h1F10_0800, 32'hFFFF_FFFF, 2'd3);
        idle();

        tag = "R7";
        for (int r = 0; r < 4; r++) begin
            logic [63:0] d;
            for (int b = 0; b < 8; b++) d[b*8 +: 8] = 8'(8'hA0 + r * 8 + b);
            do_write(2'(r), d);
        end
        idle();

        tag = "R4";
        do_req(32'h1F10_0800, 32'h0, 2'd3);
        do_req(32'h1B_0D_17_02, 32'h0, 2'd3);
        tag = "R6";
        do_req(32'h0001_0203, 32'h0, 2'd3);
        do_req(32'h0505_0505, 32'h0, 2'd3);
        tag = "R2";
        do_req(32'h0011_0000, 32'h5566_7788, 2'd3);

        tag = "R3";
        do_req(32'h0708_0F10, 32'hC1C2_C3C4, 2'd0);
        do_req(32'h0F10_1718, 32'hC1C2_C3C4, 2'd1);
        do_req(32'h1718_1F20, 32'hC1C2_C3C4, 2'd2);
        do_req(32'h1F20_0018, 32'hC1C2_C3C4, 2'd3);

        tag = "R5";
        do_req(32'h2000_2000, 32'hDEAD_BEEF, 2'd0);
        tag = "R9";
        do_req(32'hFF80_2021, 32'hDEAD_BEEF, 2'd3);
        do_req(32'h40E0_7F22, 32'h1234_5678, 2'd3);

        tag = "R8";
        idle(); idle(); idle();
        do_req(32'h0302_0100, 32'h0, 2'd0);
        idle(); idle();

        tag = "R7";
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 64'h0F0E_0D0C_0B0A_0908;
        req = 1'b1; idx_word = 32'h0706_0100; dflt_word = '0; tbl_len = 2'd0;
        do_req(32'h0706_0100, 32'h0, 2'd0);
        do_write(2'd2, 64'h1111_2222_3333_4444);
        idle();
        do_req(32'h1710_1112, 32'h0, 2'd2);

        tag = "R1";
        @(negedge clk);
        wr_en = 1'b0; req = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        do_req(32'h1F17_0F07, 32'hAAAA_AAAA, 2'd3);
        idle();

        tag = "R2";
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            wr_en = $urandom_range(0, 3) == 0;
            wr_sel = 2'($urandom);
            wr_data = {$urandom, $urandom};
            req = $urandom_range(0, 2) != 0;
            idx_word = $urandom & 32'h3F3F_3F3F;
            dflt_word = $urandom;
            tbl_len = 2'($urandom);
        end
        idle();
        idle();
        finish_run();
    end
endmodule